// File: doc/BRIEF.md
# Stability-Gated System Clock Source Selector

This block decides which clock source drives the system clock. A mode controller sets a one-cycle request together with the target mode, the clock-select field of the current mode and the clock-select field of the target mode. The block compares the two fields. When they differ, it moves its registered select output to the new code. A switch to an oscillator or to the PLL is held pending until that source's stability flag is set. Until then the old source stays selected. The cycle in which the new code becomes effective is marked by a single-cycle done pulse.

Two mode rules limit the select. The clock-off code is accepted only in the stop and test modes. The standby mode fixes the select at zero. Any code that is not defined is rejected with a single-cycle error pulse, and the current selection is kept. The stability flags come from asynchronous oscillator logic, so they pass through a synchronizer of `SYNC_STAGES` flops before they are used. The analog glitch-free multiplexer is outside this block, and the select register stands in for it.

Top module: `sysclk_switch`

## Requirements
- R1: While reset is high and on the cycle after it ends, `clk_sel` is 4'h0 and `sw_done` and `sel_err` are 0.
- R2: A request whose target field equals the current field changes nothing and raises no pulse.
- R3: Codes 4'h0 (internal RC) and 4'h1 (divided internal RC) become effective only once `irc_stable` has been seen high after synchronization.
- R4: Code 4'h2 (divided external oscillator) becomes effective only once `xosc_stable` has been seen high after synchronization.
- R5: Code 4'h4 (PLL) becomes effective only once `pll_stable` has been seen high after synchronization. While the request is pending, the old code stays on `clk_sel`. The switch lands SYNC_STAGES+1 clock edges after the flag rises.
- R6: Code 4'hF (clock off) is applied on the request edge when the target mode is stop (4'hA) or test (4'h1).
- R7: Code 4'hF requested in any other target mode raises `sel_err` for one cycle and keeps `clk_sel`.
- R8: Reserved codes (4'h3 and 4'h5 through 4'hE) raise `sel_err` for one cycle and keep `clk_sel`.
- R9: A request whose target mode is standby (4'hD) sets `clk_sel` to 4'h0 on the request edge, whatever the field and the stability flags.
- R10: While `cur_mode` is standby (4'hD), `clk_sel` is held at 4'h0 and requests are ignored without an error. Any pending switch is dropped.
- R11: `sw_done` is high for exactly the one cycle after each edge at which `clk_sel` changes, and at no other time.
- R12: A new request replaces any pending switch. The old pending target never becomes effective.
- R13: Requests that are accepted for an already stable source take effect on the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_mode | input | 4 | Mode the device is in now |
| tgt_mode | input | 4 | Mode being entered, sampled on a request |
| cur_sel | input | 4 | Clock-select field of the current mode |
| tgt_sel | input | 4 | Clock-select field of the target mode |
| switch_req | input | 1 | One-cycle strobe that starts an evaluation |
| irc_stable | input | 1 | Internal RC oscillator stable (asynchronous) |
| xosc_stable | input | 1 | External crystal oscillator stable (asynchronous) |
| pll_stable | input | 1 | PLL locked and stable (asynchronous) |
| clk_sel | output | 4 | Effective clock-select code |
| sw_done | output | 1 | One-cycle pulse when a new code takes effect |
| sel_err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The hardest situation to reach from the ports is a pending switch that another request overtakes before its source becomes stable. The stimulus leaves the PLL flag low, issues a PLL request, and then follows it with an internal RC request. Only after that does it raise the PLL flag, and it watches for several cycles that the stale PLL code never shows up. The gating latency is also checked cycle by cycle. The code must still be the old one two edges after the flag rises and must be the new one on the third.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SEL_W  = 4;
  localparam int MODE_W = 4;
  localparam int NSRC   = 3;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam sel_t SEL_IRC      = 4'h0;
  localparam sel_t SEL_IRC_DIV  = 4'h1;
  localparam sel_t SEL_XOSC_DIV = 4'h2;
  localparam sel_t SEL_PLL      = 4'h4;
  localparam sel_t SEL_OFF      = 4'hF;

  localparam mode_t MODE_TEST = 4'h1;
  localparam mode_t MODE_RUN0 = 4'h4;
  localparam mode_t MODE_STOP = 4'hA;
  localparam mode_t MODE_STBY = 4'hD;

  // index of each source inside the stable-flag vector
  localparam int IDX_IRC  = 0;
  localparam int IDX_XOSC = 1;
  localparam int IDX_PLL  = 2;

  typedef enum logic [1:0] {SRC_NONE, SRC_IRC, SRC_XOSC, SRC_PLL} src_e;
  typedef enum logic [1:0] {ACT_IDLE, ACT_WAIT, ACT_APPLY, ACT_REJECT} act_e;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clksw_decode.sv
module clksw_decode
  import clksw_pkg::*;
(
  input  mode_t tgt_mode,
  input  sel_t  cur_sel,
  input  sel_t  tgt_sel,
  output act_e  act,
  output src_e  src,
  output sel_t  new_sel
);
  always_comb begin
    act     = ACT_IDLE;
    src     = SRC_NONE;
    new_sel = tgt_sel;
    if (tgt_mode == MODE_STBY) begin
      act     = ACT_APPLY;
      new_sel = '0;
    end else if (tgt_sel != cur_sel) begin
      case (tgt_sel)
        SEL_IRC, SEL_IRC_DIV: begin act = ACT_WAIT; src = SRC_IRC;  end
        SEL_XOSC_DIV:         begin act = ACT_WAIT; src = SRC_XOSC; end
        SEL_PLL:              begin act = ACT_WAIT; src = SRC_PLL;  end
        SEL_OFF: act = (tgt_mode == MODE_STOP || tgt_mode == MODE_TEST) ? ACT_APPLY : ACT_REJECT;
        default: act = ACT_REJECT;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cur_mode,
  input  logic [3:0] tgt_mode,
  input  logic [3:0] cur_sel,
  input  logic [3:0] tgt_sel,
  input  logic       switch_req,
  input  logic       irc_stable,
  input  logic       xosc_stable,
  input  logic       pll_stable,
  output logic [3:0] clk_sel,
  output logic       sw_done,
  output logic       sel_err
);
  logic [NSRC-1:0] stab_raw, stab_s;
  act_e act;
  src_e req_src, pend_src_q, pend_src_d;
  sel_t req_sel, sel_q, sel_d, pend_sel_q, pend_sel_d;
  logic pend_q, pend_d, err_d, done_q, err_q;

  assign stab_raw[IDX_IRC]  = irc_stable;
  assign stab_raw[IDX_XOSC] = xosc_stable;
  assign stab_raw[IDX_PLL]  = pll_stable;

  clksw_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(stab_raw), .q(stab_s)
  );

  clksw_decode u_dec (
    .tgt_mode(tgt_mode), .cur_sel(cur_sel), .tgt_sel(tgt_sel),
    .act(act), .src(req_src), .new_sel(req_sel)
  );

  function automatic logic src_ready(input src_e s, input logic [NSRC-1:0] f);
    case (s)
      SRC_IRC:  return f[IDX_IRC];
      SRC_XOSC: return f[IDX_XOSC];
      SRC_PLL:  return f[IDX_PLL];
      default:  return 1'b1;
    endcase
  endfunction

  always_comb begin
    sel_d      = sel_q;
    pend_d     = pend_q;
    pend_src_d = pend_src_q;
    pend_sel_d = pend_sel_q;
    err_d      = 1'b0;
    if (cur_mode == MODE_STBY) begin
      sel_d  = '0;
      pend_d = 1'b0;
    end else if (switch_req) begin
      pend_d = 1'b0;
      case (act)
        ACT_WAIT: begin
          if (src_ready(req_src, stab_s)) begin
            sel_d = req_sel;
          end else begin
            pend_d     = 1'b1;
            pend_src_d = req_src;
            pend_sel_d = req_sel;
          end
        end
        ACT_APPLY:  sel_d = req_sel;
        ACT_REJECT: err_d = 1'b1;
        default: ;
      endcase
    end else if (pend_q && src_ready(pend_src_q, stab_s)) begin
      sel_d  = pend_sel_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      pend_q     <= 1'b0;
      pend_src_q <= SRC_NONE;
      pend_sel_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      pend_q     <= pend_d;
      pend_src_q <= pend_src_d;
      pend_sel_q <= pend_sel_d;
      done_q     <= (sel_d != sel_q);
      err_q      <= err_d;
    end
  end

  assign clk_sel = sel_q;
  assign sw_done = done_q;
  assign sel_err = err_q;

  AST_IRC_DIV_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == SEL_IRC_DIV && $past(clk_sel) != SEL_IRC_DIV) |-> $past(stab_s[IDX_IRC])); // R3
  AST_XOSC_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == SEL_XOSC_DIV && $past(clk_sel) != SEL_XOSC_DIV) |-> $past(stab_s[IDX_XOSC])); // R4
  AST_PLL_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == SEL_PLL && $past(clk_sel) != SEL_PLL) |-> $past(stab_s[IDX_PLL])); // R5
  AST_OFF_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == SEL_OFF && $past(clk_sel) != SEL_OFF) |->
      ($past(tgt_mode) == MODE_STOP || $past(tgt_mode) == MODE_TEST)); // R6
  AST_ERR_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
    sel_err |-> clk_sel == $past(clk_sel)); // R7
  AST_STBY_FORCED: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_STBY) |=> (clk_sel == '0 && !sel_err)); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sw_done && sel_err)); // R11
endmodule

// File: tb/tb_sysclk_switch.sv
`timescale 1ns/1ps
module tb_sysclk_switch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cur_mode = 4'h4, tgt_mode = 4'h4, cur_sel = 4'h0, tgt_sel = 4'h0;
  logic switch_req = 1'b0;
  logic irc_stable = 1'b1, xosc_stable = 1'b0, pll_stable = 1'b0;
  logic [3:0] clk_sel;
  logic sw_done, sel_err;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sysclk_switch dut (
    .clk(clk), .rst(rst), .cur_mode(cur_mode), .tgt_mode(tgt_mode),
    .cur_sel(cur_sel), .tgt_sel(tgt_sel), .switch_req(switch_req),
    .irc_stable(irc_stable), .xosc_stable(xosc_stable), .pll_stable(pll_stable),
    .clk_sel(clk_sel), .sw_done(sw_done), .sel_err(sel_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_out(input string tag, input int s, input int d, input int e);
    chk(clk_sel == 4'(s), {tag, " clk_sel"}, clk_sel, s);
    chk(sw_done == d[0], {tag, " sw_done"}, sw_done, d);
    chk(sel_err == e[0], {tag, " sel_err"}, sel_err, e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue a one-cycle request; returns at the negedge after the request edge
  task automatic req(input logic [3:0] m, input logic [3:0] cs, input logic [3:0] ts);
    tgt_mode = m; cur_sel = cs; tgt_sel = ts; switch_req = 1'b1;
    @(negedge clk);
    switch_req = 1'b0;
  endtask

  task automatic t_reset;
    cyc(2);
    expect_out("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    cyc(1);
    expect_out("R1 after reset", 0, 0, 0);
    cyc(4);
  endtask

  task automatic t_irc;
    req(4'h4, 4'h0, 4'h1);
    expect_out("R3 R13 irc div applied", 1, 1, 0);
    cyc(1);
    expect_out("R11 done one cycle", 1, 0, 0);
  endtask

  task automatic t_equal;
    req(4'h4, 4'h1, 4'h1);
    expect_out("R2 equal fields", 1, 0, 0);
  endtask

  task automatic t_xosc_gate;
    req(4'h4, 4'h1, 4'h2);
    expect_out("R4 pending on xosc", 1, 0, 0);
    cyc(5);
    expect_out("R4 still pending", 1, 0, 0);
    xosc_stable = 1'b1;
    cyc(2);
    expect_out("R4 not before sync", 1, 0, 0);
    cyc(1);
    expect_out("R4 xosc applied", 2, 1, 0);
  endtask

  task automatic t_pll_gate;
    req(4'h4, 4'h2, 4'h4);
    expect_out("R5 old kept", 2, 0, 0);
    cyc(4);
    expect_out("R5 still old", 2, 0, 0);
    pll_stable = 1'b1;
    cyc(2);
    expect_out("R5 not before sync", 2, 0, 0);
    cyc(1);
    expect_out("R5 pll applied", 4, 1, 0);
    cyc(1);
    expect_out("R11 pll done cleared", 4, 0, 0);
  endtask

  task automatic t_supersede;
    pll_stable = 1'b0;
    cyc(4);
    req(4'h4, 4'h4, 4'h0);
    expect_out("R13 irc immediate", 0, 1, 0);
    req(4'h4, 4'h0, 4'h4);
    expect_out("R12 pll pending", 0, 0, 0);
    req(4'h4, 4'h0, 4'h1);
    expect_out("R12 replaced by irc", 1, 1, 0);
    pll_stable = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      expect_out("R12 stale pll never lands", 1, 0, 0);
    end
  endtask

  task automatic t_off_code;
    req(4'hA, 4'h1, 4'hF);
    expect_out("R6 off in stop", 15, 1, 0);
    req(4'h4, 4'hF, 4'h0);
    expect_out("R3 back to irc", 0, 1, 0);
    req(4'h4, 4'h0, 4'hF);
    expect_out("R7 off rejected in run", 0, 0, 1);
    cyc(1);
    expect_out("R7 error one cycle", 0, 0, 0);
    req(4'h1, 4'h0, 4'hF);
    expect_out("R6 off in test", 15, 1, 0);
    req(4'h1, 4'hF, 4'h0);
    expect_out("R6 leave off", 0, 1, 0);
  endtask

  task automatic t_reserved;
    req(4'h4, 4'h0, 4'h3);
    expect_out("R8 code 3 rejected", 0, 0, 1);
    req(4'h4, 4'h0, 4'h9);
    expect_out("R8 code 9 rejected", 0, 0, 1);
    cyc(1);
    expect_out("R8 error cleared", 0, 0, 0);
  endtask

  task automatic t_stby_target;
    req(4'h4, 4'h0, 4'h4);
    expect_out("R5 pll ready immediate", 4, 1, 0);
    irc_stable = 1'b0;
    cyc(4);
    req(4'hD, 4'h4, 4'h2);
    expect_out("R9 standby forces zero", 0, 1, 0);
    irc_stable = 1'b1;
    cyc(4);
  endtask

  task automatic t_stby_current;
    req(4'h4, 4'h0, 4'h4);
    expect_out("R10 setup pll", 4, 1, 0);
    cur_mode = 4'hD;
    cyc(1);
    expect_out("R10 forced on entry", 0, 1, 0);
    req(4'h4, 4'h0, 4'h4);
    expect_out("R10 request ignored", 0, 0, 0);
    req(4'h4, 4'h0, 4'h7);
    expect_out("R10 reserved ignored", 0, 0, 0);
    cur_mode = 4'h4;
    cyc(3);
    expect_out("R10 nothing pending", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_irc();
    t_equal();
    t_xosc_gate();
    t_pll_gate();
    t_supersede();
    t_off_code();
    t_reserved();
    t_stby_target();
    t_stby_current();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule